// File: doc/BRIEF.md
# Dual-Bank Working Register File

This block stores the general working state of an 8-bit-heritage processor core. It has two complete banks of working registers. Each bank holds an accumulator, a flag byte and six general bytes. The six general bytes pair up into three 16-bit pairs, and in each pair the first-named byte is the high half. Two index registers sit outside the banks and are shared by both. Each index register can be used as a whole 16-bit value or as a separate high byte and low byte.

Two combinational read ports and one clocked write port serve the datapath. Each port uses a pair flag and a 4-bit select, so it reaches either one byte or one 16-bit pair. Two exchange strobes each take one cycle:
- One swaps which bank supplies the accumulator and flags.
- The other swaps the bank for the three general pairs, all together.

Main code and an interrupt handler can therefore each keep a full working set without copying any data.

Top module: `dual_bank_regfile`

## Requirements
- R1: After reset, both bank selects point at the main bank and every register, in both banks and in the index registers, reads as zero.
- R2: A byte access (pair flag 0) uses select codes 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=F, 7=A, 8=IX high, 9=IX low, 10=IY high, 11=IY low. A byte read returns the byte in bits 7:0 with bits 15:8 zero. A byte write stores wr_data[7:0] at the next clock edge.
- R3: A pair read (pair flag 1) uses codes 0=BC, 1=DE, 2=HL, 3=AF, 4=IX, 5=IY. It returns the first-named byte in bits 15:8 and the second in bits 7:0.
- R4: A pair write stores wr_data[15:8] in the high byte and wr_data[7:0] in the low byte, both at the same clock edge.
- R5: A pulse on xchg_af switches which bank supplies A and F from the next cycle on. It leaves the banks of B through L unchanged.
- R6: A pulse on xchg_gp switches the bank for B, C, D, E, H and L together from the next cycle on. It leaves A and F unchanged.
- R7: A write in the same cycle as an exchange of its register group goes into the bank that was active before that exchange.
- R8: IX and IY are shared by both banks. The exchange strobes never change them, and their whole-register and byte accesses refer to the same storage.
- R9: An unused select reads as zero and a write to it changes no register. For bytes the unused codes are 12 to 15, and for pairs they are 6 to 15.
- R10: The two read ports work independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_pair | input | 1 | Read port 0 pair flag |
| rd0_sel | input | 4 | Read port 0 select |
| rd0_data | output | 16 | Read port 0 data |
| rd1_pair | input | 1 | Read port 1 pair flag |
| rd1_sel | input | 4 | Read port 1 select |
| rd1_data | output | 16 | Read port 1 data |
| wr_en | input | 1 | Write enable |
| wr_pair | input | 1 | Write pair flag |
| wr_sel | input | 4 | Write select |
| wr_data | input | 16 | Write data |
| xchg_af | input | 1 | Exchange the accumulator/flag bank |
| xchg_gp | input | 1 | Exchange the general-pair bank |

## Verification
Reads are combinational, so a wrong bank-select bit or a misrouted write shows up on a read port in the first cycle after the edge that caused it. The bench exchanges banks, writes into the alternate bank and exchanges back. A bank bit that flips when it should not, or a write that lands in the wrong bank, then shows up as a stale or foreign value in a named pair. Writes to unused codes are followed by a full read-back of every pair, so that a stray store becomes visible.

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd0_pair,
  input  logic [3:0]      rd0_sel,
  output logic [2*DW-1:0] rd0_data,
  input  logic            rd1_pair,
  input  logic [3:0]      rd1_sel,
  output logic [2*DW-1:0] rd1_data,
  input  logic            wr_en,
  input  logic            wr_pair,
  input  logic [3:0]      wr_sel,
  input  logic [2*DW-1:0] wr_data,
  input  logic            xchg_af,
  input  logic            xchg_gp
);
  localparam int PW = 2 * DW;

  logic                    af_bank, gp_bank;
  logic [1:0][1:0][DW-1:0] afr;   // [bank][0=A,1=F]
  logic [1:0][5:0][DW-1:0] gpr;   // [bank][B,C,D,E,H,L]
  logic [3:0][DW-1:0]      idx;   // IXH, IXL, IYH, IYL

  logic [DW-1:0] wr_hi, wr_lo;
  assign wr_hi = wr_data[PW-1:DW];
  assign wr_lo = wr_data[DW-1:0];

  function automatic logic [PW-1:0] fetch(input logic pr, input logic [3:0] s);
    logic [PW-1:0] v;
    v = '0;
    if (pr) begin
      case (s)
        4'd0, 4'd1, 4'd2: v = {gpr[gp_bank][{s[1:0], 1'b0}], gpr[gp_bank][{s[1:0], 1'b1}]};
        4'd3:             v = {afr[af_bank][0], afr[af_bank][1]};
        4'd4:             v = {idx[0], idx[1]};
        4'd5:             v = {idx[2], idx[3]};
        default:          v = '0;
      endcase
    end else begin
      case (s)
        4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: v = {{DW{1'b0}}, gpr[gp_bank][s[2:0]]};
        4'd6:                               v = {{DW{1'b0}}, afr[af_bank][1]};
        4'd7:                               v = {{DW{1'b0}}, afr[af_bank][0]};
        4'd8, 4'd9, 4'd10, 4'd11:           v = {{DW{1'b0}}, idx[s[1:0]]};
        default:                            v = '0;
      endcase
    end
    return v;
  endfunction

  assign rd0_data = fetch(rd0_pair, rd0_sel);
  assign rd1_data = fetch(rd1_pair, rd1_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_bank <= 1'b0;
      gp_bank <= 1'b0;
      afr     <= '0;
      gpr     <= '0;
      idx     <= '0;
    end else begin
      af_bank <= af_bank ^ xchg_af;
      gp_bank <= gp_bank ^ xchg_gp;
      if (wr_en) begin
        if (wr_pair) begin
          case (wr_sel)
            4'd0, 4'd1, 4'd2: begin
              gpr[gp_bank][{wr_sel[1:0], 1'b0}] <= wr_hi;
              gpr[gp_bank][{wr_sel[1:0], 1'b1}] <= wr_lo;
            end
            4'd3: begin
              afr[af_bank][0] <= wr_hi;
              afr[af_bank][1] <= wr_lo;
            end
            4'd4: begin
              idx[0] <= wr_hi;
              idx[1] <= wr_lo;
            end
            4'd5: begin
              idx[2] <= wr_hi;
              idx[3] <= wr_lo;
            end
            default: ;
          endcase
        end else begin
          case (wr_sel)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: gpr[gp_bank][wr_sel[2:0]] <= wr_lo;
            4'd6:                               afr[af_bank][1] <= wr_lo;
            4'd7:                               afr[af_bank][0] <= wr_lo;
            4'd8, 4'd9, 4'd10, 4'd11:           idx[wr_sel[1:0]] <= wr_lo;
            default: ;
          endcase
        end
      end
    end
  end

  assert_af_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_af |=> (af_bank != $past(af_bank)));
  assert_af_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !xchg_af |=> $stable(af_bank));
  assert_gp_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_gp |=> (gp_bank != $past(gp_bank)));
  assert_gp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !xchg_gp |=> $stable(gp_bank));
  assert_pair_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pair && wr_sel == 4'd1) |=>
      (gpr[$past(gp_bank)][2] == $past(wr_data[PW-1:DW]) &&
       gpr[$past(gp_bank)][3] == $past(wr_data[DW-1:0])));
  assert_old_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_pair && wr_sel == 4'd7) |=>
      (afr[$past(af_bank)][0] == $past(wr_data[DW-1:0])));
  assert_idx_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(idx));
  assert_bad_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_pair && rd0_sel > 4'd5) |-> (rd0_data == '0));
  assert_bad_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_pair && wr_sel > 4'd11) |=>
      ($stable(gpr) && $stable(afr) && $stable(idx)));
endmodule

// File: tb/dual_bank_regfile_tb.sv
module dual_bank_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd0_pair = 1'b0, rd1_pair = 1'b0;
  logic [3:0]  rd0_sel = '0, rd1_sel = '0;
  logic [15:0] rd0_data, rd1_data;
  logic        wr_en = 1'b0, wr_pair = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        xchg_af = 1'b0, xchg_gp = 1'b0;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dual_bank_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd0_pair(rd0_pair), .rd0_sel(rd0_sel), .rd0_data(rd0_data),
    .rd1_pair(rd1_pair), .rd1_sel(rd1_sel), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_pair(wr_pair), .wr_sel(wr_sel), .wr_data(wr_data),
    .xchg_af(xchg_af), .xchg_gp(xchg_gp)
  );

  task automatic op(input logic we, input logic pr, input logic [3:0] s,
                    input logic [15:0] d, input logic xa, input logic xg);
    wr_en = we; wr_pair = pr; wr_sel = s; wr_data = d; xchg_af = xa; xchg_gp = xg;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_pair = 1'b0; wr_sel = '0; wr_data = '0; xchg_af = 1'b0; xchg_gp = 1'b0;
  endtask

  task automatic chk0(input logic pr, input logic [3:0] s, input logic [15:0] exp, input string req);
    rd0_pair = pr; rd0_sel = s; #1;
    total++;
    if (rd0_data !== exp) begin
      bad++;
      $display("FAIL %s port0 pair=%0d sel=%0d actual=%h expected=%h", req, pr, s, rd0_data, exp);
    end
  endtask

  task automatic chk1(input logic pr, input logic [3:0] s, input logic [15:0] exp, input string req);
    rd1_pair = pr; rd1_sel = s; #1;
    total++;
    if (rd1_data !== exp) begin
      bad++;
      $display("FAIL %s port1 pair=%0d sel=%0d actual=%h expected=%h", req, pr, s, rd1_data, exp);
    end
  endtask

  task automatic t_reset;  // R1
    for (int p = 0; p < 6; p++) chk0(1'b1, 4'(p), 16'h0000, "R1");
    chk1(1'b1, 4'd3, 16'h0000, "R1");
  endtask

  task automatic t_bytes;  // R2, R3
    op(1, 0, 4'd0, 16'h0011, 0, 0);
    op(1, 0, 4'd1, 16'h0022, 0, 0);
    op(1, 0, 4'd2, 16'h0033, 0, 0);
    op(1, 0, 4'd3, 16'h0044, 0, 0);
    op(1, 0, 4'd4, 16'h0055, 0, 0);
    op(1, 0, 4'd5, 16'hFF66, 0, 0);
    op(1, 0, 4'd6, 16'h00F0, 0, 0);
    op(1, 0, 4'd7, 16'h00A0, 0, 0);
    chk0(1'b0, 4'd0, 16'h0011, "R2");
    chk0(1'b0, 4'd5, 16'h0066, "R2");
    chk0(1'b0, 4'd6, 16'h00F0, "R2");
    chk0(1'b1, 4'd0, 16'h1122, "R3");
    chk0(1'b1, 4'd2, 16'h5566, "R3");
    chk0(1'b1, 4'd3, 16'hA0F0, "R3");
  endtask

  task automatic t_pair_write;  // R4
    op(1, 1, 4'd1, 16'hABCD, 0, 0);
    chk0(1'b0, 4'd2, 16'h00AB, "R4");
    chk0(1'b0, 4'd3, 16'h00CD, "R4");
  endtask

  task automatic t_xchg_af;  // R5
    op(0, 0, 4'd0, 16'h0000, 1, 0);
    chk0(1'b1, 4'd3, 16'h0000, "R5");
    chk0(1'b1, 4'd0, 16'h1122, "R5");
    op(1, 0, 4'd7, 16'h005A, 0, 0);
    chk0(1'b1, 4'd3, 16'h5A00, "R5");
    op(0, 0, 4'd0, 16'h0000, 1, 0);
    chk0(1'b1, 4'd3, 16'hA0F0, "R5");
  endtask

  task automatic t_xchg_gp;  // R6
    op(0, 0, 4'd0, 16'h0000, 0, 1);
    chk0(1'b1, 4'd0, 16'h0000, "R6");
    chk0(1'b1, 4'd3, 16'hA0F0, "R6");
    op(1, 1, 4'd2, 16'hBEEF, 0, 0);
    chk0(1'b1, 4'd2, 16'hBEEF, "R6");
    op(0, 0, 4'd0, 16'h0000, 0, 1);
    chk0(1'b1, 4'd2, 16'h5566, "R6");
    chk0(1'b1, 4'd1, 16'hABCD, "R6");
  endtask

  task automatic t_concurrent;  // R7
    op(1, 0, 4'd0, 16'h0099, 0, 1);
    chk0(1'b0, 4'd0, 16'h0000, "R7");
    op(0, 0, 4'd0, 16'h0000, 0, 1);
    chk0(1'b1, 4'd0, 16'h9922, "R7");
    op(1, 1, 4'd3, 16'h1357, 1, 0);
    chk0(1'b1, 4'd3, 16'h5A00, "R7");
    op(0, 0, 4'd0, 16'h0000, 1, 0);
    chk0(1'b1, 4'd3, 16'h1357, "R7");
  endtask

  task automatic t_index;  // R8
    op(1, 1, 4'd4, 16'h1234, 0, 0);
    chk0(1'b0, 4'd8, 16'h0012, "R8");
    chk0(1'b0, 4'd9, 16'h0034, "R8");
    op(1, 0, 4'd11, 16'h009A, 0, 0);
    chk0(1'b1, 4'd5, 16'h009A, "R8");
    op(0, 0, 4'd0, 16'h0000, 1, 1);
    chk0(1'b1, 4'd4, 16'h1234, "R8");
    chk0(1'b1, 4'd5, 16'h009A, "R8");
    op(0, 0, 4'd0, 16'h0000, 1, 1);
  endtask

  task automatic t_invalid;  // R9
    op(1, 1, 4'd6, 16'hFFFF, 0, 0);
    op(1, 0, 4'd12, 16'hFFFF, 0, 0);
    op(1, 1, 4'd15, 16'hFFFF, 0, 0);
    chk0(1'b1, 4'd7, 16'h0000, "R9");
    chk0(1'b0, 4'd14, 16'h0000, "R9");
    chk0(1'b1, 4'd0, 16'h9922, "R9");
    chk0(1'b1, 4'd1, 16'hABCD, "R9");
    chk0(1'b1, 4'd2, 16'h5566, "R9");
    chk0(1'b1, 4'd3, 16'h1357, "R9");
    chk0(1'b1, 4'd4, 16'h1234, "R9");
    chk0(1'b1, 4'd5, 16'h009A, "R9");
  endtask

  task automatic t_dual;  // R10
    rd0_pair = 1'b1; rd0_sel = 4'd0;
    rd1_pair = 1'b1; rd1_sel = 4'd2; #1;
    total++;
    if (rd0_data !== 16'h9922 || rd1_data !== 16'h5566) begin
      bad++;
      $display("FAIL R10 actual=%h/%h expected=9922/5566", rd0_data, rd1_data);
    end
    chk1(1'b0, 4'd7, 16'h0013, "R10");
    chk0(1'b0, 4'd1, 16'h0022, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_pair_write();
    t_xchg_af();
    t_xchg_gp();
    t_concurrent();
    t_index();
    t_invalid();
    t_dual();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule